// File: doc/BRIEF.md
# Dual-Mode Serial Transceiver with Address Filtering

This block is a serial port core for a larger chip. In asynchronous mode it sends and receives at the same time. Frames begin with a low start bit and carry 8 or 9 data bits, least significant bit first. An optional parity bit follows the data, then one or two high stop bits. In synchronous mode it moves 8-bit words in one direction at a time. The block drives the shift clock out on the transmit pin, and the receive pin carries data in either direction under an output-enable.

Software-facing logic outside the block writes words into a transmit holding register and takes received words from a receive holding register. Each path also has a separate shift register, so a second word can wait while the first is on the line. Bit timing comes from an external tick at sixteen times the asynchronous bit rate. Four one-cycle interrupt pulses go to an external controller. A multiprocessor option uses the ninth bit as an address marker and can discard data frames. A loop-back option routes the transmit line to the receiver for self test.

Top module: `ser_xcvr`

## Requirements
- R1: In asynchronous mode `txd_o` idles high. A frame sends a low start bit, then 8 data bits (`nine_bit_i`=0) or 9 (`nine_bit_i`=1), LSB first. Every bit lasts 16 baud ticks.
- R2: With `par_en_i`=1 a parity bit directly follows the data bits. It makes the count of ones over data plus parity even (`par_odd_i`=0) or odd (`par_odd_i`=1). A received parity mismatch sets `par_err_o` and pulses `err_irq_o`.
- R3: A transmitted frame ends with one high stop bit (`two_stop_i`=0) or two (`two_stop_i`=1). A queued word's start bit follows at once.
- R4: A write to the transmit holding register while a frame is being sent is kept, and that word is sent straight after the current one. `tx_empty_irq_o` pulses once each time the holding word moves to the shifter. `tx_done_irq_o` pulses once at the end of each frame.
- R5: A received frame is stored in `rx_data_o`, raises `rx_valid_o` and pulses `rx_full_irq_o`. `rx_rd_i` frees the register. Bits are taken by majority of three samples at the bit centre. A low pulse shorter than half a bit is not taken as a start bit.
- R6: A received stop bit sampled low sets `frm_err_o` and pulses `err_irq_o`. The data is still stored.
- R7: A frame that completes while `rx_valid_o` is high and not being read keeps the old word. The new frame is discarded, `ovr_err_o` is set and `err_irq_o` pulses.
- R8: With `addr_wake_i`=1 and 9-bit frames, frames whose bit 8 is 0 (data) are dropped without any effect. Frames whose bit 8 is 1 (address) are received.
- R9: With `loopback_i`=1 the asynchronous receiver takes the transmit line instead of `rxd_i`.
- R10: In synchronous mode with `rx_en_i`=0, a written word goes out on `rxd_o` with `rxd_oe_o`=1, LSB first. `txd_o` carries 8 clock pulses (low then high, one baud tick per half). Data changes while the clock is low and is valid at the rising edge. `tx_done_irq_o` pulses at the end.
- R11: In synchronous mode with `rx_en_i`=1 the block keeps `rxd_oe_o` low, drives 8 clock pulses on `txd_o` and samples `rxd_i` at each rising edge, LSB first. It stores the word with bit 8 = 0. A transfer in progress completes even if `rx_en_i` falls.
- R12: After reset `txd_o`=1, `rxd_oe_o`=0, `rx_valid_o`=0 and all error flags are 0. The error flags stay set until `err_clr_i` is pulsed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| baud_tick_i | input | 1 | One-cycle pulse at 16x the asynchronous bit rate |
| sync_mode_i | input | 1 | 1 selects synchronous mode |
| rx_en_i | input | 1 | Synchronous mode: receive instead of transmit |
| nine_bit_i | input | 1 | 9 data bits per asynchronous frame |
| par_en_i | input | 1 | Parity bit present |
| par_odd_i | input | 1 | Odd parity when set |
| two_stop_i | input | 1 | Two stop bits on transmit |
| addr_wake_i | input | 1 | Drop data frames, keep address frames |
| loopback_i | input | 1 | Receiver fed from transmit line |
| tx_data_i | input | 9 | Word to transmit |
| tx_wr_i | input | 1 | Write `tx_data_i` into the transmit holding register |
| rx_data_o | output | 9 | Received word |
| rx_valid_o | output | 1 | Receive holding register full |
| rx_rd_i | input | 1 | Free the receive holding register |
| par_err_o | output | 1 | Sticky parity error |
| frm_err_o | output | 1 | Sticky framing error |
| ovr_err_o | output | 1 | Sticky overrun error |
| err_clr_i | input | 1 | Clear all error flags |
| rxd_i | input | 1 | Receive pin input |
| rxd_o | output | 1 | Receive pin output (synchronous transmit data) |
| rxd_oe_o | output | 1 | Output enable for the receive pin |
| txd_o | output | 1 | Transmit data, or shift clock in synchronous mode |
| tx_empty_irq_o | output | 1 | Pulse: transmit holding register emptied |
| tx_done_irq_o | output | 1 | Pulse: last bit of a frame sent |
| rx_full_irq_o | output | 1 | Pulse: word stored for reading |
| err_irq_o | output | 1 | Pulse: parity, framing or overrun error |

## Verification
The transmitter is tried with an 8-bit frame with one stop bit, and with a 9-bit even-parity frame with two stop bits. In each case a second word is queued behind the first, so frame length and back-to-back hand-over are both visible. The receiver gets a clean frame, a short glitch, a frame with wrong parity and a frame with a low stop bit. These separate start validation from parity and from stop checking. Two unread frames test overrun retention. A data frame and an address frame under address wake test the filter. An odd-parity loop-back with `rxd_i` held low shows that the internal path is used. Patterns of mixed ones and zeros in both synchronous directions show bit order and clock edge placement.

// File: rtl/ser_pkg.sv
package ser_pkg;
  localparam int unsigned OVS_DEF   = 16;
  localparam int unsigned DW        = 9;
  localparam int unsigned SYNC_BITS = 8;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS} rx_st_e;

  function automatic logic calc_par(logic [DW-1:0] d, logic nine, logic odd);
    logic [DW-1:0] m;
    m = d;
    if (!nine) m[DW-1] = 1'b0;
    return (^m) ^ odd;
  endfunction
endpackage

// File: rtl/ser_async_tx.sv
module ser_async_tx
  import ser_pkg::*;
#(
  parameter int unsigned OVS = OVS_DEF
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          tick_i,
  input  logic          hv_i,
  input  logic [DW-1:0] hold_i,
  input  logic          nine_i,
  input  logic          par_en_i,
  input  logic          par_odd_i,
  input  logic          two_stop_i,
  output logic          load_o,
  output logic          done_o,
  output logic          txd_o
);
  localparam int unsigned FW  = DW + 4;
  localparam int unsigned NBW = $clog2(FW + 1);
  localparam int unsigned CW  = $clog2(OVS);

  logic           busy;
  logic [FW-1:0]  sh, frm;
  logic [NBW-1:0] nbits, bidx, nb;
  logic [CW-1:0]  tcnt;

  always_comb begin
    frm    = '1;
    frm[0] = 1'b0;
    for (int i = 0; i < int'(DW); i++)
      if (i < int'(DW) - 1 || nine_i) frm[i+1] = hold_i[i];
    if (par_en_i) begin
      if (nine_i) frm[DW+1] = calc_par(hold_i, nine_i, par_odd_i);
      else        frm[DW]   = calc_par(hold_i, nine_i, par_odd_i);
    end
    nb = NBW'(DW) + NBW'(nine_i) + NBW'(par_en_i) + (two_stop_i ? NBW'(2) : NBW'(1));
  end

  assign load_o = en_i && !busy && hv_i;
  assign txd_o  = busy ? sh[0] : 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy <= 1'b0; sh <= '1; nbits <= '0; bidx <= '0; tcnt <= '0; done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (load_o) begin
        busy <= 1'b1; sh <= frm; nbits <= nb; bidx <= '0; tcnt <= '0;
      end else if (busy && tick_i) begin
        if (tcnt == CW'(OVS - 1)) begin
          tcnt <= '0;
          sh   <= {1'b1, sh[FW-1:1]};
          bidx <= bidx + 1'b1;
          if (bidx == nbits - NBW'(1)) begin
            busy   <= 1'b0;
            done_o <= 1'b1;
          end
        end else begin
          tcnt <= tcnt + 1'b1;
        end
      end
    end
  end

  a_r1_start_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> !txd_o);
endmodule

// File: rtl/ser_async_rx.sv
module ser_async_rx
  import ser_pkg::*;
#(
  parameter int unsigned OVS = OVS_DEF
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          tick_i,
  input  logic          rxd_i,
  input  logic          nine_i,
  input  logic          par_en_i,
  input  logic          par_odd_i,
  output logic          done_o,
  output logic [DW-1:0] data_o,
  output logic          perr_o,
  output logic          ferr_o
);
  localparam int unsigned CW  = $clog2(OVS);
  localparam int unsigned MID = OVS / 2 + 1;
  localparam int unsigned IW  = $clog2(DW + 3);

  rx_st_e        st;
  logic [CW-1:0] phase;
  logic [IW-1:0] idx, nd;
  logic [DW-1:0] sh;
  logic          s_a, s_b, pbit, maj;

  assign nd     = nine_i ? IW'(DW) : IW'(DW - 1);
  assign maj    = (s_a & s_b) | (s_a & rxd_i) | (s_b & rxd_i);
  assign data_o = nine_i ? sh : {1'b0, sh[DW-2:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st <= RX_IDLE; phase <= '0; s_a <= 1'b1; s_b <= 1'b1; idx <= '0; sh <= '0;
      pbit <= 1'b0; done_o <= 1'b0; perr_o <= 1'b0; ferr_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (!en_i) begin
        st <= RX_IDLE;
      end else if (st == RX_IDLE) begin
        if (!rxd_i) begin
          st <= RX_START; phase <= '0; sh <= '0;
        end
      end else if (tick_i) begin
        phase <= (phase == CW'(OVS - 1)) ? '0 : phase + 1'b1;
        if (phase == CW'(MID - 2)) s_a <= rxd_i;
        if (phase == CW'(MID - 1)) s_b <= rxd_i;
        if (phase == CW'(MID)) begin
          if (st == RX_START) begin
            if (maj) st <= RX_IDLE;   // start not confirmed at centre
            else begin st <= RX_BITS; idx <= '0; end
          end else begin
            idx <= idx + 1'b1;
            if (idx < nd) sh[idx] <= maj;
            else if (par_en_i && idx == nd) pbit <= maj;
            else begin
              done_o <= 1'b1;
              ferr_o <= !maj;
              perr_o <= par_en_i && (pbit != calc_par(sh, nine_i, par_odd_i));
              st     <= RX_IDLE;
            end
          end
        end
      end
    end
  end

  a_r5_done_from_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(st) == RX_BITS);
endmodule

// File: rtl/ser_sync.sv
module ser_sync
  import ser_pkg::*;
#(
  parameter int unsigned BITS = SYNC_BITS
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            tick_i,
  input  logic            rx_en_i,
  input  logic            hv_i,
  input  logic [BITS-1:0] hold_i,
  input  logic            rxd_i,
  output logic            load_o,
  output logic            tx_done_o,
  output logic            rx_done_o,
  output logic [BITS-1:0] data_o,
  output logic            sclk_o,
  output logic            sdo_o,
  output logic            oe_o
);
  localparam int unsigned CW = $clog2(2 * BITS);

  logic            run, dir_rx;
  logic [CW-1:0]   cnt;
  logic [BITS-1:0] sh;

  assign load_o = en_i && !run && !rx_en_i && hv_i;
  assign oe_o   = run && !dir_rx;
  assign data_o = sh;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run <= 1'b0; dir_rx <= 1'b0; cnt <= '0; sh <= '0; sclk_o <= 1'b1; sdo_o <= 1'b0;
      tx_done_o <= 1'b0; rx_done_o <= 1'b0;
    end else begin
      tx_done_o <= 1'b0;
      rx_done_o <= 1'b0;
      if (!en_i) begin
        run <= 1'b0; sclk_o <= 1'b1;
      end else if (!run) begin
        if (rx_en_i) begin
          run <= 1'b1; dir_rx <= 1'b1; cnt <= '0;
        end else if (load_o) begin
          run <= 1'b1; dir_rx <= 1'b0; cnt <= '0; sh <= hold_i;
        end
      end else if (tick_i) begin
        cnt <= cnt + 1'b1;
        if (!cnt[0]) begin
          sclk_o <= 1'b0;
          if (!dir_rx) sdo_o <= sh[0];
        end else begin
          sclk_o <= 1'b1;
          sh     <= dir_rx ? {rxd_i, sh[BITS-1:1]} : {1'b0, sh[BITS-1:1]};
          if (cnt == CW'(2 * BITS - 1)) begin
            run       <= 1'b0;
            tx_done_o <= !dir_rx;
            rx_done_o <= dir_rx;
          end
        end
      end
    end
  end

  a_r11_sclk_idle_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |-> sclk_o);
  a_r10_oe_only_sync: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_o |-> $past(en_i));
endmodule

// File: rtl/ser_xcvr.sv
module ser_xcvr
  import ser_pkg::*;
#(
  parameter int unsigned OVS = OVS_DEF
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          baud_tick_i,
  input  logic          sync_mode_i,
  input  logic          rx_en_i,
  input  logic          nine_bit_i,
  input  logic          par_en_i,
  input  logic          par_odd_i,
  input  logic          two_stop_i,
  input  logic          addr_wake_i,
  input  logic          loopback_i,
  input  logic [DW-1:0] tx_data_i,
  input  logic          tx_wr_i,
  output logic [DW-1:0] rx_data_o,
  output logic          rx_valid_o,
  input  logic          rx_rd_i,
  output logic          par_err_o,
  output logic          frm_err_o,
  output logic          ovr_err_o,
  input  logic          err_clr_i,
  input  logic          rxd_i,
  output logic          rxd_o,
  output logic          rxd_oe_o,
  output logic          txd_o,
  output logic          tx_empty_irq_o,
  output logic          tx_done_irq_o,
  output logic          rx_full_irq_o,
  output logic          err_irq_o
);
  logic [DW-1:0]        tx_hold, rx_hold, ar_data, rx_word;
  logic                 tx_hv, rx_hv;
  logic [1:0]           rx_sync;
  logic                 atx_load, atx_done, atx_txd;
  logic                 ar_done, ar_perr, ar_ferr, rx_line;
  logic                 sy_load, sy_tx_done, sy_rx_done, sy_sclk;
  logic [SYNC_BITS-1:0] sy_data;
  logic                 tx_load, rx_evt, drop, rx_busy, store, ovr_evt, perr_set, ferr_set;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) rx_sync <= 2'b11;
    else         rx_sync <= {rx_sync[0], rxd_i};

  assign rx_line = loopback_i ? atx_txd : rx_sync[1];

  ser_async_tx #(.OVS(OVS)) u_atx (
    .clk_i, .rst_ni, .en_i(!sync_mode_i), .tick_i(baud_tick_i), .hv_i(tx_hv),
    .hold_i(tx_hold), .nine_i(nine_bit_i), .par_en_i, .par_odd_i, .two_stop_i,
    .load_o(atx_load), .done_o(atx_done), .txd_o(atx_txd));

  ser_async_rx #(.OVS(OVS)) u_arx (
    .clk_i, .rst_ni, .en_i(!sync_mode_i), .tick_i(baud_tick_i), .rxd_i(rx_line),
    .nine_i(nine_bit_i), .par_en_i, .par_odd_i, .done_o(ar_done), .data_o(ar_data),
    .perr_o(ar_perr), .ferr_o(ar_ferr));

  ser_sync #(.BITS(SYNC_BITS)) u_sync (
    .clk_i, .rst_ni, .en_i(sync_mode_i), .tick_i(baud_tick_i), .rx_en_i,
    .hv_i(tx_hv), .hold_i(tx_hold[SYNC_BITS-1:0]), .rxd_i(rx_sync[1]),
    .load_o(sy_load), .tx_done_o(sy_tx_done), .rx_done_o(sy_rx_done), .data_o(sy_data),
    .sclk_o(sy_sclk), .sdo_o(rxd_o), .oe_o(rxd_oe_o));

  assign txd_o   = sync_mode_i ? sy_sclk : atx_txd;
  assign tx_load = atx_load | sy_load;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_hold <= '0; tx_hv <= 1'b0;
    end else if (tx_wr_i) begin
      tx_hold <= tx_data_i; tx_hv <= 1'b1;
    end else if (tx_load) begin
      tx_hv <= 1'b0;
    end
  end

  assign rx_evt   = (ar_done && !sync_mode_i) || sy_rx_done;
  assign rx_word  = sync_mode_i ? DW'(sy_data) : ar_data;
  assign drop     = !sync_mode_i && addr_wake_i && nine_bit_i && !ar_data[DW-1];
  assign rx_busy  = rx_hv && !rx_rd_i;
  assign store    = rx_evt && !drop && !rx_busy;
  assign ovr_evt  = rx_evt && !drop && rx_busy;
  assign perr_set = store && !sync_mode_i && ar_perr;
  assign ferr_set = store && !sync_mode_i && ar_ferr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_hold <= '0; rx_hv <= 1'b0;
      par_err_o <= 1'b0; frm_err_o <= 1'b0; ovr_err_o <= 1'b0;
      tx_empty_irq_o <= 1'b0; tx_done_irq_o <= 1'b0; rx_full_irq_o <= 1'b0; err_irq_o <= 1'b0;
    end else begin
      if (store) begin
        rx_hold <= rx_word; rx_hv <= 1'b1;
      end else if (rx_rd_i) begin
        rx_hv <= 1'b0;
      end
      par_err_o      <= (par_err_o & !err_clr_i) | perr_set;
      frm_err_o      <= (frm_err_o & !err_clr_i) | ferr_set;
      ovr_err_o      <= (ovr_err_o & !err_clr_i) | ovr_evt;
      tx_empty_irq_o <= tx_load;
      tx_done_irq_o  <= atx_done | sy_tx_done;
      rx_full_irq_o  <= store;
      err_irq_o      <= ovr_evt | perr_set | ferr_set;
    end
  end

  assign rx_data_o  = rx_hold;
  assign rx_valid_o = rx_hv;

  a_r5_full_has_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_full_irq_o |-> rx_valid_o);
  a_r7_hold_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_evt |=> $stable(rx_hold));
  a_r12_frm_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_err_o && !err_clr_i |=> frm_err_o);
  a_r4_one_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(atx_load && sy_load));
endmodule

// File: tb/tb_ser_xcvr.sv
module tb_ser_xcvr;
  logic clk = 0, rst_n = 0, tick;
  logic sync_mode = 0, rx_en = 0, nine = 0, pe = 0, po = 0, two = 0, aw = 0, lb = 0;
  logic [8:0] tx_data = '0;
  logic tx_wr = 0, mon_rd = 0, mon_clr = 0, man_rd = 0, man_clr = 0, rxd = 1;
  logic [8:0] rx_data;
  logic rx_valid, perr, ferr, oerr, rxd_out, rxd_oe, txd;
  logic i_empty, i_done, i_full, i_err;
  logic [1:0] tdiv;
  int n_tot = 0, n_bad = 0, n_empty = 0, n_done = 0, n_full = 0, n_err = 0;
  bit mon_en = 1, fin = 0;
  logic [10:0] exp_q[$];

  always #10 clk = ~clk;

  ser_xcvr dut (
    .clk_i(clk), .rst_ni(rst_n), .baud_tick_i(tick), .sync_mode_i(sync_mode), .rx_en_i(rx_en),
    .nine_bit_i(nine), .par_en_i(pe), .par_odd_i(po), .two_stop_i(two), .addr_wake_i(aw),
    .loopback_i(lb), .tx_data_i(tx_data), .tx_wr_i(tx_wr), .rx_data_o(rx_data),
    .rx_valid_o(rx_valid), .rx_rd_i(mon_rd | man_rd), .par_err_o(perr), .frm_err_o(ferr),
    .ovr_err_o(oerr), .err_clr_i(mon_clr | man_clr), .rxd_i(rxd), .rxd_o(rxd_out),
    .rxd_oe_o(rxd_oe), .txd_o(txd), .tx_empty_irq_o(i_empty), .tx_done_irq_o(i_done),
    .rx_full_irq_o(i_full), .err_irq_o(i_err));

  always @(posedge clk or negedge rst_n)
    if (!rst_n) begin tdiv <= '0; tick <= 1'b0; end
    else begin tdiv <= tdiv + 1'b1; tick <= (tdiv == 2'd3); end

  always @(posedge clk) begin
    if (i_empty) n_empty <= n_empty + 1;
    if (i_done)  n_done  <= n_done + 1;
    if (i_full)  n_full  <= n_full + 1;
    if (i_err)   n_err   <= n_err + 1;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tot++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] mk_frame(logic [8:0] d, bit nn, bit p_en, bit p_odd);
    logic [15:0] f; int k; logic p;
    f = '1; f[0] = 1'b0; k = 1; p = p_odd;
    for (int i = 0; i < (nn ? 9 : 8); i++) begin f[k] = d[i]; p ^= d[i]; k++; end
    if (p_en) f[k] = p;
    return f;
  endfunction

  function automatic int fr_len(bit nn, bit p_en, bit tw);
    return 1 + (nn ? 9 : 8) + (p_en ? 1 : 0) + (tw ? 2 : 1);
  endfunction

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [8:0] d);
    @(negedge clk); tx_data = d; tx_wr = 1;
    @(negedge clk); tx_wr = 0;
  endtask

  task automatic cap_tx(input int n, output logic [15:0] c);
    c = '1;
    @(negedge txd);
    wait_clk(32); c[0] = txd;
    for (int i = 1; i < n; i++) begin wait_clk(64); c[i] = txd; end
  endtask

  task automatic send_rx(input logic [8:0] d, input bit flip_par, input bit bad_stop);
    logic [15:0] f; int n;
    f = mk_frame(d, nine, pe, po);
    n = fr_len(nine, pe, 1'b0);
    if (flip_par) f[n-2] = ~f[n-2];
    if (bad_stop) f[n-1] = 1'b0;
    for (int i = 0; i < n; i++) begin rxd = f[i]; wait_clk(64); end
    rxd = 1; wait_clk(64);
  endtask

  // scoreboard monitor: pops expected {perr, ferr, data}
  initial forever begin
    @(negedge clk);
    if (mon_en && i_full) begin
      if (exp_q.size() == 0) chk("R5 unexpected word", {perr, ferr, rx_data}, 32'hFFF);
      else begin
        logic [10:0] e;
        e = exp_q.pop_front();
        chk("R5/R2/R6 rx word", {perr, ferr, rx_data}, e);
      end
      mon_rd = 1; mon_clr = 1;
      @(negedge clk); mon_rd = 0; mon_clr = 0;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!fin) begin
      n_tot++; n_bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", n_tot, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] c, e;
    logic [7:0] sb;
    int base_e, base_d, base_f, base_r, n;
    bit oe_seen;
    wait_clk(3); rst_n = 1; wait_clk(3);
    // R12 reset state
    chk("R12 txd idle", txd, 1);
    chk("R12 oe", rxd_oe, 0);
    chk("R12 valid", rx_valid, 0);
    chk("R12 flags", {perr, ferr, oerr}, 0);

    // R1/R3/R4: 8-bit, 1 stop, two words back to back
    base_e = n_empty; base_d = n_done;
    n = fr_len(0, 0, 0);
    fork
      cap_tx(n + 1, c);
      begin wr(9'h035); wr(9'h0C9); end
    join
    e = mk_frame(9'h035, 0, 0, 0); e[n] = 1'b0;
    chk("R1/R3 8-bit frame", c[10:0], e[10:0]);
    wait_clk(64 * 12);
    chk("R4 empty irqs", n_empty - base_e, 2);
    chk("R4 done irqs", n_done - base_d, 2);

    // R2/R3: 9-bit even parity, two stops
    nine = 1; pe = 1; two = 1;
    n = fr_len(1, 1, 1);
    fork
      cap_tx(n + 1, c);
      begin wr(9'h13A); wr(9'h0F0); end
    join
    e = mk_frame(9'h13A, 1, 1, 0); e[n] = 1'b0;
    chk("R2/R3 9-bit parity 2 stop", c[13:0], e[13:0]);
    wait_clk(64 * 15);

    // R9 loopback, odd parity, pin held low
    nine = 0; pe = 1; po = 1; two = 0;
    lb = 1; rxd = 0;
    exp_q.push_back({2'b00, 9'h0A5});
    wr(9'h0A5);
    wait_clk(64 * 13);
    chk("R9 loopback consumed", exp_q.size(), 0);
    rxd = 1; wait_clk(4); lb = 0;

    // R5 clean receive
    pe = 0; po = 0;
    base_f = n_full;
    exp_q.push_back({2'b00, 9'h096});
    send_rx(9'h096, 0, 0);
    chk("R5 word taken", exp_q.size(), 0);
    chk("R5 full irq", n_full - base_f, 1);

    // R5 glitch rejected
    base_f = n_full;
    rxd = 0; wait_clk(20); rxd = 1; wait_clk(1000);
    chk("R5 glitch ignored valid", rx_valid, 0);
    chk("R5 glitch no irq", n_full - base_f, 0);

    // R2 parity error
    pe = 1; base_r = n_err;
    exp_q.push_back({2'b10, 9'h05A});
    send_rx(9'h05A, 1, 0);
    chk("R2 parity err irq", n_err - base_r, 1);
    chk("R12 parity cleared", perr, 0);

    // R6 framing error
    pe = 0; base_r = n_err;
    exp_q.push_back({2'b01, 9'h03C});
    send_rx(9'h03C, 0, 1);
    wait_clk(64);
    chk("R6 frame err irq", n_err - base_r, 1);
    chk("R12 frame cleared", ferr, 0);
    chk("R6 queue", exp_q.size(), 0);

    // R7 overrun
    mon_en = 0; base_r = n_err;
    send_rx(9'h011, 0, 0);
    send_rx(9'h022, 0, 0);
    chk("R7 old word kept", rx_data, 9'h011);
    chk("R7 overrun flag", oerr, 1);
    chk("R7 err irq", n_err - base_r, 1);
    @(negedge clk); man_rd = 1; man_clr = 1;
    @(negedge clk); man_rd = 0; man_clr = 0;
    chk("R12 overrun cleared", oerr, 0);
    chk("R7 freed", rx_valid, 0);
    mon_en = 1;

    // R8 address wake
    nine = 1; aw = 1; base_f = n_full;
    send_rx(9'h055, 0, 0);
    chk("R8 data frame dropped", rx_valid, 0);
    chk("R8 no irq", n_full - base_f, 0);
    exp_q.push_back({2'b00, 9'h1AA});
    send_rx(9'h1AA, 0, 0);
    chk("R8 address taken", exp_q.size(), 0);
    aw = 0; nine = 0;

    // R10 synchronous transmit
    sync_mode = 1; base_d = n_done; oe_seen = 0;
    fork
      for (int i = 0; i < 8; i++) begin
        @(posedge txd); oe_seen |= rxd_oe; sb[i] = rxd_out;
      end
      wr(9'h06B);
    join
    chk("R10 sync data", sb, 8'h6B);
    chk("R10 oe during tx", oe_seen, 1);
    wait_clk(20);
    chk("R10 oe released", rxd_oe, 0);
    chk("R10 done irq", n_done - base_d, 1);

    // R11 synchronous receive
    exp_q.push_back({2'b00, 9'h09C});
    oe_seen = 0;
    @(negedge clk); rx_en = 1;
    for (int i = 0; i < 8; i++) begin
      @(negedge txd); oe_seen |= rxd_oe;
      rxd = sb[0] ^ sb[0] ^ ((8'h9C >> i) & 1);
    end
    rx_en = 0;
    wait_clk(40); rxd = 1;
    chk("R11 sync word", exp_q.size(), 0);
    chk("R11 oe low", oe_seen, 0);
    sync_mode = 0;
    wait_clk(20);

    fin = 1;
    $display("test done: total=%0d bad=%0d", n_tot, n_bad);
    $finish;
  end
endmodule